// File: doc/BRIEF.md
# Register window control unit

This block keeps the bookkeeping state of a processor's rotating register windows: the current window pointer, the count of windows that can still be saved into, the count that can be restored from, the count of windows belonging to another context, the count of clean windows, a six-bit trap-select word and the global level. The pipeline hands it one command per cycle: save, restore or flush-windows. For each command the block either commits the new window state at the next clock edge or raises a trap request. A trap request carries a trap kind and a vector offset, and in that case the state is left exactly as it was.

Trap selection works as follows. When the other-context count is nonzero, spill and fill traps use the "other" vector family, indexed by bits 5:3 of the select word. Otherwise they use the "normal" family, indexed by bits 2:0. The offset reported is four times the chosen three-bit field. A save that finds no savable window raises a spill trap. This check comes before the clean-window check, which fires when the clean count equals the restorable count.

Privileged software reads the state through a five-bit register number, and the number decode flags illegal numbers with their own trap. Privileged writes load each register directly through the same numbering. Trap entry, handler code and the register file itself sit outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window pointer, restorable, clean and other-context counts, select word and global level read 0, the savable count reads NWIN-2, and trap_valid_o is low.
- R2: A save (cmd_i=1) that raises no trap advances the window pointer by one modulo NWIN, lowers the savable count by one and raises the restorable count by one.
- R3: A save with a savable count of zero raises a spill trap, whatever the clean and restorable counts are; the spill check wins over the clean-window check.
- R4: A save with a nonzero savable count and a clean count equal to the restorable count raises a clean-window trap (kind 5, offset 0).
- R5: Spill and fill traps use the "other" kinds (spill 2, fill 4) with field wstate[5:3] when the other-context count is nonzero, and otherwise the "normal" kinds (spill 1, fill 3) with field wstate[2:0]; trap_off_o equals four times that field.
- R6: A restore (cmd_i=2) that raises no trap moves the window pointer back by one modulo NWIN, raises the savable count by one and lowers the restorable count by one.
- R7: A restore with a restorable count of zero raises a fill trap under the rule of R5.
- R8: A flush-windows command (cmd_i=3) raises a spill trap under the rule of R5 when the savable count differs from NWIN-2, and otherwise changes nothing and raises no trap.
- R9: A trap appears as trap_valid_o high for exactly the one cycle after the triggering command, and the window pointer and counts keep their values across that edge; trap kinds are 0 none, 1 spill normal, 2 spill other, 3 fill normal, 4 fill other, 5 clean window, 6 illegal read.
- R10: The register numbers read back zero-extended on rd_data_o: 0x09 pointer, 0x0A savable, 0x0B restorable, 0x0C clean, 0x0D other-context, 0x0E select word, 0x10 global level; numbers 0x00 to 0x08 read 0.
- R11: A read strobe (rd_valid_i) with number 0x0F or 0x11 to 0x1F raises an illegal-read trap (kind 6, offset 0) in the next cycle; other numbers raise none.
- R12: A write (wr_en_i) loads the numbered register from the low bits of wr_data_i (all six bits for the select word, log2(NWIN) bits for the pointer and counts, GLW bits for the global level); writes to unmapped numbers change nothing.
- R13: A command has priority: a write or a read strobe in the same cycle as a command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 idle, 1 save, 2 restore, 3 flush-windows |
| rd_valid_i | input | 1 | Privileged read strobe (enables the illegal-number trap) |
| rd_num_i | input | 5 | Register number for reads |
| rd_data_o | output | 8 | Read data, combinational from rd_num_i |
| wr_en_i | input | 1 | Privileged write strobe |
| wr_num_i | input | 5 | Register number for writes |
| wr_data_i | input | 6 | Write data |
| trap_valid_o | output | 1 | Trap request, one-cycle pulse |
| trap_kind_o | output | 3 | Trap kind, encoding as in R9 |
| trap_off_o | output | 5 | Vector offset |

## Verification
The assertions assume that NWIN is a power of two. Under that assumption, counter arithmetic that wraps at the register width matches the modulo rule, so the step checks for save and restore hold without a range guard. They also rely on the command having priority over writes, so a write strobe left high during a command does not break the step properties. The stimulus loads every combination of savable, restorable and clean counts, with the other-context count zero and nonzero. It then issues each command from a quiet cycle and reads the state back only after the trap pulse has ended.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_SAVE    = 2'd1,
    CMD_RESTORE = 2'd2,
    CMD_FLUSH   = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    TRAP_NONE     = 3'd0,
    TRAP_SPILL_NRM = 3'd1,
    TRAP_SPILL_OTH = 3'd2,
    TRAP_FILL_NRM  = 3'd3,
    TRAP_FILL_OTH  = 3'd4,
    TRAP_CLEAN     = 3'd5,
    TRAP_ILLEGAL   = 3'd6
  } trap_e;

  localparam logic [4:0] RN_CWP   = 5'h09;
  localparam logic [4:0] RN_CSAVE = 5'h0A;
  localparam logic [4:0] RN_CREST = 5'h0B;
  localparam logic [4:0] RN_CLEAN = 5'h0C;
  localparam logic [4:0] RN_OTHER = 5'h0D;
  localparam logic [4:0] RN_WSEL  = 5'h0E;
  localparam logic [4:0] RN_HOLE  = 5'h0F;
  localparam logic [4:0] RN_GLVL  = 5'h10;
endpackage

// File: rtl/regwin_trap_sel.sv
module regwin_trap_sel
  import regwin_pkg::*;
(
  input  logic       is_fill_i,
  input  logic       other_i,
  input  logic [5:0] wsel_i,
  output trap_e      kind_o,
  output logic [4:0] off_o
);
  logic [2:0] fld;

  always_comb begin
    fld   = other_i ? wsel_i[5:3] : wsel_i[2:0];
    off_o = {fld, 2'b00};
    unique case ({is_fill_i, other_i})
      2'b00:   kind_o = TRAP_SPILL_NRM;
      2'b01:   kind_o = TRAP_SPILL_OTH;
      2'b10:   kind_o = TRAP_FILL_NRM;
      default: kind_o = TRAP_FILL_OTH;
    endcase
  end
endmodule

// File: rtl/regwin_cmd_eval.sv
module regwin_cmd_eval
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int W = $clog2(NWIN)
) (
  input  cmd_e         cmd_i,
  input  logic [W-1:0] cwp_i,
  input  logic [W-1:0] csave_i,
  input  logic [W-1:0] crest_i,
  input  logic [W-1:0] clean_i,
  input  logic [W-1:0] other_i,
  input  logic [5:0]   wsel_i,
  output logic         upd_o,
  output logic [W-1:0] cwp_o,
  output logic [W-1:0] csave_o,
  output logic [W-1:0] crest_o,
  output trap_e        trap_o,
  output logic [4:0]   off_o
);
  localparam logic [W-1:0] TOP_IDX   = W'(NWIN - 1);
  localparam logic [W-1:0] FLUSH_REF = W'(NWIN - 2);

  trap_e      sf_kind;
  logic [4:0] sf_off;

  regwin_trap_sel u_sel (
    .is_fill_i (cmd_i == CMD_RESTORE),
    .other_i   (other_i != '0),
    .wsel_i    (wsel_i),
    .kind_o    (sf_kind),
    .off_o     (sf_off)
  );

  always_comb begin
    upd_o   = 1'b0;
    cwp_o   = cwp_i;
    csave_o = csave_i;
    crest_o = crest_i;
    trap_o  = TRAP_NONE;
    off_o   = '0;
    unique case (cmd_i)
      CMD_SAVE: begin
        if (csave_i == '0) begin
          trap_o = sf_kind;
          off_o  = sf_off;
        end else if (clean_i == crest_i) begin
          trap_o = TRAP_CLEAN;
        end else begin
          upd_o   = 1'b1;
          cwp_o   = (cwp_i == TOP_IDX) ? '0 : cwp_i + W'(1);
          csave_o = csave_i - W'(1);
          crest_o = crest_i + W'(1);
        end
      end
      CMD_RESTORE: begin
        if (crest_i == '0) begin
          trap_o = sf_kind;
          off_o  = sf_off;
        end else begin
          upd_o   = 1'b1;
          cwp_o   = (cwp_i == '0) ? TOP_IDX : cwp_i - W'(1);
          csave_o = csave_i + W'(1);
          crest_o = crest_i - W'(1);
        end
      end
      CMD_FLUSH: begin
        if (csave_i != FLUSH_REF) begin
          trap_o = sf_kind;
          off_o  = sf_off;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regwin_priv_rd.sv
module regwin_priv_rd
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int GLW  = 3,
  localparam int W = $clog2(NWIN)
) (
  input  logic [4:0]     num_i,
  input  logic [W-1:0]   cwp_i,
  input  logic [W-1:0]   csave_i,
  input  logic [W-1:0]   crest_i,
  input  logic [W-1:0]   clean_i,
  input  logic [W-1:0]   other_i,
  input  logic [5:0]     wsel_i,
  input  logic [GLW-1:0] glvl_i,
  output logic [7:0]     data_o,
  output logic           illegal_o
);
  always_comb begin
    data_o    = '0;
    illegal_o = (num_i == RN_HOLE) || (num_i > RN_GLVL);
    unique case (num_i)
      RN_CWP:   data_o = 8'(cwp_i);
      RN_CSAVE: data_o = 8'(csave_i);
      RN_CREST: data_o = 8'(crest_i);
      RN_CLEAN: data_o = 8'(clean_i);
      RN_OTHER: data_o = 8'(other_i);
      RN_WSEL:  data_o = 8'(wsel_i);
      RN_GLVL:  data_o = 8'(glvl_i);
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int GLW  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       rd_valid_i,
  input  logic [4:0] rd_num_i,
  output logic [7:0] rd_data_o,
  input  logic       wr_en_i,
  input  logic [4:0] wr_num_i,
  input  logic [5:0] wr_data_i,
  output logic       trap_valid_o,
  output logic [2:0] trap_kind_o,
  output logic [4:0] trap_off_o
);
  localparam int W = $clog2(NWIN);
  localparam logic [W-1:0] CSAVE_RST = W'(NWIN - 2);

  cmd_e           cmd;
  logic [W-1:0]   cwp_q, csave_q, crest_q, clean_q, other_q;
  logic [5:0]     wsel_q;
  logic [GLW-1:0] glvl_q;

  logic           upd;
  logic [W-1:0]   cwp_n, csave_n, crest_n;
  trap_e          cmd_trap, trap_n;
  logic [4:0]     cmd_off, off_n;
  logic           rd_ill;

  assign cmd = cmd_e'(cmd_i);

  regwin_cmd_eval #(.NWIN(NWIN)) u_eval (
    .cmd_i   (cmd),
    .cwp_i   (cwp_q),
    .csave_i (csave_q),
    .crest_i (crest_q),
    .clean_i (clean_q),
    .other_i (other_q),
    .wsel_i  (wsel_q),
    .upd_o   (upd),
    .cwp_o   (cwp_n),
    .csave_o (csave_n),
    .crest_o (crest_n),
    .trap_o  (cmd_trap),
    .off_o   (cmd_off)
  );

  regwin_priv_rd #(.NWIN(NWIN), .GLW(GLW)) u_rd (
    .num_i     (rd_num_i),
    .cwp_i     (cwp_q),
    .csave_i   (csave_q),
    .crest_i   (crest_q),
    .clean_i   (clean_q),
    .other_i   (other_q),
    .wsel_i    (wsel_q),
    .glvl_i    (glvl_q),
    .data_o    (rd_data_o),
    .illegal_o (rd_ill)
  );

  // commands outrank read strobes
  always_comb begin
    trap_n = TRAP_NONE;
    off_n  = '0;
    if (cmd != CMD_IDLE) begin
      trap_n = cmd_trap;
      off_n  = cmd_off;
    end else if (rd_valid_i && rd_ill) begin
      trap_n = TRAP_ILLEGAL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q        <= '0;
      csave_q      <= CSAVE_RST;
      crest_q      <= '0;
      clean_q      <= '0;
      other_q      <= '0;
      wsel_q       <= '0;
      glvl_q       <= '0;
      trap_valid_o <= 1'b0;
      trap_kind_o  <= '0;
      trap_off_o   <= '0;
    end else begin
      if (cmd != CMD_IDLE) begin
        if (upd) begin
          cwp_q   <= cwp_n;
          csave_q <= csave_n;
          crest_q <= crest_n;
        end
      end else if (wr_en_i) begin
        unique case (wr_num_i)
          RN_CWP:   cwp_q   <= wr_data_i[W-1:0];
          RN_CSAVE: csave_q <= wr_data_i[W-1:0];
          RN_CREST: crest_q <= wr_data_i[W-1:0];
          RN_CLEAN: clean_q <= wr_data_i[W-1:0];
          RN_OTHER: other_q <= wr_data_i[W-1:0];
          RN_WSEL:  wsel_q  <= wr_data_i;
          RN_GLVL:  glvl_q  <= wr_data_i[GLW-1:0];
          default: ;
        endcase
      end
      trap_valid_o <= (trap_n != TRAP_NONE);
      trap_kind_o  <= trap_n;
      trap_off_o   <= off_n;
    end
  end

  // R2
  save_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_SAVE && upd) |=>
      (cwp_q == (($past(cwp_q) == W'(NWIN - 1)) ? '0 : W'($past(cwp_q) + 1)))
      && (csave_q == W'($past(csave_q) - 1)) && (crest_q == W'($past(crest_q) + 1)));

  // R6
  restore_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RESTORE && upd) |=>
      (cwp_q == (($past(cwp_q) == '0) ? W'(NWIN - 1) : W'($past(cwp_q) - 1)))
      && (csave_q == W'($past(csave_q) + 1)) && (crest_q == W'($past(crest_q) - 1)));

  // R3
  spill_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_SAVE && csave_q == '0) |=>
      trap_valid_o && (trap_kind_o == TRAP_SPILL_NRM || trap_kind_o == TRAP_SPILL_OTH));

  // R9
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |-> (cwp_q == $past(cwp_q)) && (csave_q == $past(csave_q))
                     && (crest_q == $past(crest_q)));

  // R9
  trap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_o && cmd == CMD_IDLE && !rd_valid_i) |=> !trap_valid_o);

  // R11
  illegal_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_IDLE && rd_valid_i && rd_num_i == RN_HOLE) |=>
      trap_valid_o && trap_kind_o == TRAP_ILLEGAL);
endmodule

// File: tb/regwin_ctrl_test.sv
module regwin_ctrl_test;
  localparam int NW = 8;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic [1:0] cmd_i;
  logic       rd_valid_i;
  logic [4:0] rd_num_i;
  logic [7:0] rd_data_o;
  logic       wr_en_i;
  logic [4:0] wr_num_i;
  logic [5:0] wr_data_i;
  logic       trap_valid_o;
  logic [2:0] trap_kind_o;
  logic [4:0] trap_off_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  regwin_ctrl #(.NWIN(NW), .GLW(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i),
    .rd_valid_i(rd_valid_i), .rd_num_i(rd_num_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_num_i(wr_num_i), .wr_data_i(wr_data_i),
    .trap_valid_o(trap_valid_o), .trap_kind_o(trap_kind_o), .trap_off_o(trap_off_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] n, input logic [5:0] d);
    wr_en_i = 1'b1; wr_num_i = n; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] n, output logic [7:0] d, output logic tv,
                    output logic [2:0] tk);
    rd_valid_i = 1'b1; rd_num_i = n;
    #1 d = rd_data_o;
    @(negedge clk);
    rd_valid_i = 1'b0;
    tv = trap_valid_o; tk = trap_kind_o;
  endtask

  task automatic issue(input logic [1:0] c, output logic tv, output logic [2:0] tk,
                       output logic [4:0] to);
    cmd_i = c;
    @(negedge clk);
    cmd_i = 2'd0;
    tv = trap_valid_o; tk = trap_kind_o; to = trap_off_o;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    logic tv;
    logic [2:0] tk;
    logic [4:0] to;
    rst_ni = 1'b0; cmd_i = 2'd0; rd_valid_i = 1'b0; rd_num_i = '0;
    wr_en_i = 1'b0; wr_num_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 trap_valid", trap_valid_o, 0);
    rd(5'h09, d, tv, tk); chk("R1 cwp", d, 0);
    rd(5'h0A, d, tv, tk); chk("R1 savable", d, NW - 2);
    rd(5'h0B, d, tv, tk); chk("R1 restorable", d, 0);
    rd(5'h0C, d, tv, tk); chk("R1 clean", d, 0);
    rd(5'h0D, d, tv, tk); chk("R1 other", d, 0);
    rd(5'h0E, d, tv, tk); chk("R1 wsel", d, 0);
    rd(5'h10, d, tv, tk); chk("R1 glvl", d, 0);

    // R10 R11 read map sweep
    wr(5'h0C, 6'd3); wr(5'h0D, 6'd2); wr(5'h0E, 6'h2B); wr(5'h10, 6'd5);
    wr(5'h09, 6'd4); wr(5'h0A, 6'd1); wr(5'h0B, 6'd6);
    for (int n = 0; n < 32; n++) begin
      int ed;
      int et;
      case (n)
        9: ed = 4; 10: ed = 1; 11: ed = 6; 12: ed = 3;
        13: ed = 2; 14: ed = 'h2B; 16: ed = 5;
        default: ed = 0;
      endcase
      et = (n == 15 || n >= 17) ? 1 : 0;
      rd(5'(n), d, tv, tk);
      chk("R10 read data", d, ed);
      chk("R11 illegal trap", tv, et);
      if (et == 1) chk("R11 illegal kind", tk, 6);
    end

    // R12 writes: width limits and unmapped numbers
    wr(5'h0E, 6'h3F);
    rd(5'h0E, d, tv, tk); chk("R12 wsel six bits", d, 63);
    wr(5'h09, 6'h2D);
    rd(5'h09, d, tv, tk); chk("R12 cwp low bits", d, 5);
    wr(5'h15, 6'h11); wr(5'h0F, 6'h11); wr(5'h03, 6'h11);
    rd(5'h0E, d, tv, tk); chk("R12 unmapped write wsel", d, 63);
    rd(5'h09, d, tv, tk); chk("R12 unmapped write cwp", d, 5);
    rd(5'h0C, d, tv, tk); chk("R12 unmapped write clean", d, 3);

    // R13 command beats concurrent write and read strobe
    wr(5'h09, 6'd2); wr(5'h0A, 6'd3); wr(5'h0B, 6'd1); wr(5'h0C, 6'd5);
    wr_en_i = 1'b1; wr_num_i = 5'h09; wr_data_i = 6'd7;
    rd_valid_i = 1'b1; rd_num_i = 5'h0F;
    issue(2'd1, tv, tk, to);
    wr_en_i = 1'b0; rd_valid_i = 1'b0;
    chk("R13 no trap from read", tv, 0);
    rd(5'h09, d, tv, tk); chk("R13 write ignored cwp", d, 3);

    // R2..R9 exhaustive sweep over the counts
    for (int cs = 0; cs < NW; cs++)
      for (int cr = 0; cr < NW; cr++)
        for (int cw = 0; cw < NW; cw++)
          for (int oi = 0; oi < 2; oi++)
            for (int c = 1; c < 4; c++) begin
              int ow, cwp0, ws, ek, eo, ncwp, ncs, ncr, fld;
              string rq;
              ow   = oi * 2;
              cwp0 = (cs + cr + cw) % NW;
              ws   = (cs * 5 + cr * 3 + cw * 7 + ow + c) & 63;
              fld  = (ow != 0) ? ((ws >> 3) & 7) : (ws & 7);
              ek = 0; eo = 0; ncwp = cwp0; ncs = cs; ncr = cr;
              rq = "R2";
              if (c == 1) begin
                if (cs == 0) begin
                  ek = (ow != 0) ? 2 : 1; eo = 4 * fld; rq = "R3";
                end else if (cw == cr) begin
                  ek = 5; rq = "R4";
                end else begin
                  ncwp = (cwp0 + 1) % NW; ncs = cs - 1; ncr = (cr + 1) % NW;
                end
              end else if (c == 2) begin
                rq = "R6";
                if (cr == 0) begin
                  ek = (ow != 0) ? 4 : 3; eo = 4 * fld; rq = "R7";
                end else begin
                  ncwp = (cwp0 + NW - 1) % NW; ncs = (cs + 1) % NW; ncr = cr - 1;
                end
              end else begin
                rq = "R8";
                if (cs != NW - 2) begin
                  ek = (ow != 0) ? 2 : 1; eo = 4 * fld;
                end
              end
              wr(5'h09, 6'(cwp0)); wr(5'h0A, 6'(cs)); wr(5'h0B, 6'(cr));
              wr(5'h0C, 6'(cw)); wr(5'h0D, 6'(ow)); wr(5'h0E, 6'(ws));
              issue(2'(c), tv, tk, to);
              chk({rq, " trap_valid"}, tv, (ek != 0) ? 1 : 0);
              chk({rq, " trap_kind"}, tk, ek);
              if (ek >= 1 && ek <= 4) chk("R5 vector offset", to, eo);
              rd(5'h09, d, tv, tk);
              chk("R9 single pulse", tv, 0);
              chk({rq, (ek != 0) ? " R9 cwp held" : " cwp"}, d, ncwp);
              rd(5'h0A, d, tv, tk); chk({rq, " savable"}, d, ncs);
              rd(5'h0B, d, tv, tk); chk({rq, " restorable"}, d, ncr);
            end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule